// File: doc/BRIEF.md
# Two-Wire Bus Stall Watchdog

This block protects a two-wire serial slave against a bus that hangs in the middle of a transfer. The synchronized clock and data lines first pass through a deglitch stage. A level change is handed on only after it has been seen on several consecutive system clocks, so spikes shorter than `GLITCH_NS` never reach the protocol engine. The filtered lines are driven out for that engine to use.

A watchdog arms when the protocol engine reports a valid start. While it is armed, it counts the system clocks during which either filtered line sits low. When the count reaches the programmed limit, the block emits a single-cycle reset strobe. The protocol engine uses this strobe to release its data driver and return to waiting for a start. The count restarts whenever both lines are high. A stop or a timeout disarms the watchdog until the next start.

A register bit outside the block drives `enable_i`. When that bit is low, the watchdog is switched off. The default parameters give a limit of 45 ms (2,250,000 clocks at 50 MHz). That value lies in the middle of the required 30 ms to 60 ms window. It applies equally to a stall while the master writes and to a stall while it reads.

Top module: `bus_stall_watchdog`

## Requirements
- R1: In reset and on leaving it, `bus_reset_o` is 0 and `scl_o` and `sda_o` are 1.
- R2: A filtered line takes a new raw level only after that level has been sampled on FILT consecutive rising clock edges, with FILT = floor(GLITCH_NS*CLK_MHZ/1000)+2 (4 at the defaults). The change is visible after the FILT-th edge. A raw pulse shorter than FILT cycles leaves the filtered line unchanged.
- R3: Without a `start_i` pulse since reset or since the last disarm, held-low lines never produce a strobe.
- R4: After a start with `enable_i` = 1, filtered SCL held low for T = TIMEOUT_US*CLK_MHZ consecutive counted edges gives exactly one 1-cycle `bus_reset_o` pulse. The first counted edge is the one after the start edge, and the pulse appears after the T-th counted edge.
- R5: A stall with SDA held low and SCL high times out in the same way as R4.
- R6: Any cycle in which both filtered lines are high clears the count, so the limit restarts from zero.
- R7: A `stop_i` pulse disarms the watchdog and clears the count.
- R8: After a timeout the watchdog is disarmed, and lines kept low give no further strobe until the next `start_i`.
- R9: While `enable_i` is 0 the watchdog is disarmed and cleared. After `enable_i` returns to 1, a new start is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized raw clock line |
| sda_i | input | 1 | Synchronized raw data line |
| start_i | input | 1 | One-cycle pulse: valid start seen |
| stop_i | input | 1 | One-cycle pulse: stop seen |
| enable_i | input | 1 | Watchdog enable from control register |
| scl_o | output | 1 | Deglitched clock line |
| sda_o | output | 1 | Deglitched data line |
| bus_reset_o | output | 1 | One-cycle interface reset strobe |

## Verification
The bench keeps `CLK_MHZ` = 50 and `GLITCH_NS` = 50, so the filter runs with its production depth of 4 samples. It sets `TIMEOUT_US` = 1, which shrinks the limit to 50 clocks. With that limit, full timeouts, a count restarted by an idle gap, and repeated re-arming all fit in a few hundred cycles. The exact clock of every strobe can then be checked against a count kept in the bench.

// File: rtl/stall_pkg.sv
package stall_pkg;
  typedef enum logic {
    WD_IDLE  = 1'b0,
    WD_WATCH = 1'b1
  } wd_state_e;

  function automatic int unsigned filt_depth(int unsigned glitch_ns, int unsigned clk_mhz);
    return (glitch_ns * clk_mhz) / 1000 + 2;
  endfunction
endpackage

// File: rtl/line_deglitch.sv
module line_deglitch #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  logic [CW-1:0] run_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      lvl_q <= 1'b1;
    end else if (raw_i == lvl_q) begin
      run_q <= '0;
    end else if (run_q == CW'(DEPTH - 1)) begin
      run_q <= '0;
      lvl_q <= raw_i;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign filt_o = lvl_q;

  // R2: filtered level only moves to a level the raw line held
  a_r2_follows_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> ($past(raw_i) == lvl_q));
endmodule

// File: rtl/stall_arm.sv
module stall_arm
  import stall_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic fire_i,
  output logic armed_o
);
  wd_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!enable_i)                           st_d = WD_IDLE;
    else if (st_q == WD_WATCH && (stop_i || fire_i)) st_d = WD_IDLE;
    else if (start_i)                        st_d = WD_WATCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= WD_IDLE;
    else         st_q <= st_d;
  end

  assign armed_o = (st_q == WD_WATCH);

  // R9: disabled cycle leaves watchdog disarmed
  a_r9_disable_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !armed_o);
  // R8: timeout disarms
  a_r8_fire_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> !armed_o);
endmodule

// File: rtl/stall_counter.sv
module stall_counter #(
  parameter int unsigned LIMIT = 2_250_000,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic enable_i,
  input  logic stop_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic fire_o,
  output logic strobe_o
);
  logic [CW-1:0] cnt_q;
  logic          clr;
  logic          hit;
  logic          strobe_q;

  assign clr    = !armed_i || !enable_i || stop_i || (scl_i && sda_i);
  assign hit    = !clr && (cnt_q == CW'(LIMIT - 1));
  assign fire_o = hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= hit;
      if (clr || hit) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
    end
  end

  assign strobe_o = strobe_q;

  // R4: strobe is a single cycle
  a_r4_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |=> !strobe_q);
  // R3: no strobe unless the watchdog was armed
  a_r3_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> !strobe_q);
  // R6: idle bus cannot time out
  a_r6_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && sda_i) |=> (cnt_q == '0 && !strobe_q));
  // R7: stop clears the count
  a_r7_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (cnt_q == '0 && !strobe_q));
  a_r4_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT));
endmodule

// File: rtl/bus_stall_watchdog.sv
module bus_stall_watchdog
  import stall_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 50,
  parameter int unsigned GLITCH_NS  = 50,
  parameter int unsigned TIMEOUT_US = 45_000,
  localparam int unsigned FILT   = filt_depth(GLITCH_NS, CLK_MHZ),
  localparam int unsigned LIMIT  = TIMEOUT_US * CLK_MHZ,
  localparam int unsigned NLINES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic enable_i,
  output logic scl_o,
  output logic sda_o,
  output logic bus_reset_o
);
  logic [NLINES-1:0] raw, filt;
  logic armed, fire;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    line_deglitch #(.DEPTH(FILT)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[g]),
      .filt_o(filt[g])
    );
  end

  assign scl_o = filt[0];
  assign sda_o = filt[1];

  stall_arm u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .start_i (start_i),
    .stop_i  (stop_i),
    .fire_i  (fire),
    .armed_o (armed)
  );

  stall_counter #(.LIMIT(LIMIT)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (armed),
    .enable_i(enable_i),
    .stop_i  (stop_i),
    .scl_i   (filt[0]),
    .sda_i   (filt[1]),
    .fire_o  (fire),
    .strobe_o(bus_reset_o)
  );

  // R9: disabled watchdog never strobes
  a_r9_enable_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !bus_reset_o);
endmodule

// File: tb/bus_stall_watchdog_test.sv
module bus_stall_watchdog_test;
  localparam int FILT = 4;
  localparam int T    = 50;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_r = 1'b1, sda_r = 1'b1, start_r = 1'b0, stop_r = 1'b0, en_r = 1'b1;
  logic scl_o, sda_o, bus_reset_o;

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  int exp_q[$];
  int obs_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  bus_stall_watchdog #(.CLK_MHZ(50), .GLITCH_NS(50), .TIMEOUT_US(1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_r), .sda_i(sda_r),
    .start_i(start_r), .stop_i(stop_r), .enable_i(en_r),
    .scl_o(scl_o), .sda_o(sda_o), .bus_reset_o(bus_reset_o)
  );

  // monitor
  always @(negedge clk) if (rst_ni && bus_reset_o) obs_q.push_back(cyc);

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_sb(string req);
    chk({req, " strobe count"}, obs_q.size(), exp_q.size());
    while (exp_q.size() > 0 && obs_q.size() > 0)
      chk({req, " strobe cycle"}, obs_q.pop_front(), exp_q.pop_front());
    exp_q.delete();
    obs_q.delete();
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start(output int c0);
    @(negedge clk) start_r = 1'b1;
    @(negedge clk) start_r = 1'b0;
    c0 = cyc;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_r = 1'b1;
    @(negedge clk) stop_r = 1'b0;
  endtask

  task automatic idle_bus();
    @(negedge clk) begin scl_r = 1'b1; sda_r = 1'b1; end
    wait_n(FILT + 3);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int c0, cr;
    // R1 reset state
    wait_n(3);
    chk("R1 reset strobe", bus_reset_o, 0);
    chk("R1 reset scl", scl_o, 1);
    chk("R1 reset sda", sda_o, 1);
    @(negedge clk) rst_ni = 1'b1;
    wait_n(2);
    chk("R1 after release sda", sda_o, 1);

    // R2 short glitch rejected
    @(negedge clk) sda_r = 1'b0;
    wait_n(FILT - 1);
    sda_r = 1'b1;
    for (int i = 0; i < 2 * FILT; i++) begin
      chk("R2 glitch held", sda_o, 1);
      @(negedge clk);
    end
    // R2 full-length level passes after FILT edges
    scl_r = 1'b0;
    for (int i = 1; i <= FILT + 1; i++) begin
      @(negedge clk);
      chk("R2 scl fall timing", scl_o, (i >= FILT) ? 0 : 1);
    end
    scl_r = 1'b1;
    for (int i = 1; i <= FILT + 1; i++) begin
      @(negedge clk);
      chk("R2 scl rise timing", scl_o, (i >= FILT) ? 1 : 0);
    end

    // R3 low lines with no start
    @(negedge clk) scl_r = 1'b0;
    wait_n(3 * T);
    idle_bus();
    check_sb("R3");

    // R4 SCL stall, then R8 no repeat, then re-arm
    @(negedge clk) scl_r = 1'b0;
    wait_n(FILT + 2);
    pulse_start(c0);
    exp_q.push_back(c0 + T);
    wait_n(3 * T);
    check_sb("R4/R8");
    pulse_start(c0);
    exp_q.push_back(c0 + T);
    wait_n(T + 5);
    idle_bus();
    check_sb("R8 rearm");

    // R5 SDA stall
    @(negedge clk) sda_r = 1'b0;
    wait_n(FILT + 2);
    pulse_start(c0);
    exp_q.push_back(c0 + T);
    wait_n(2 * T);
    idle_bus();
    check_sb("R5");

    // R6 idle gap restarts the count
    @(negedge clk) scl_r = 1'b0;
    wait_n(FILT + 2);
    pulse_start(c0);
    while (cyc < c0 + (T - FILT - 2)) @(negedge clk);
    scl_r = 1'b1;
    wait_n(FILT + 1);
    scl_r = 1'b0;
    @(negedge clk) cr = cyc;
    exp_q.push_back(cr + FILT + T - 1);
    wait_n(2 * T);
    idle_bus();
    check_sb("R6");

    // R7 stop disarms
    @(negedge clk) sda_r = 1'b0;
    wait_n(FILT + 2);
    pulse_start(c0);
    wait_n(T / 2);
    pulse_stop();
    wait_n(2 * T);
    idle_bus();
    check_sb("R7");

    // R9 enable low: start ignored
    @(negedge clk) begin scl_r = 1'b0; en_r = 1'b0; end
    wait_n(FILT + 2);
    pulse_start(c0);
    wait_n(2 * T);
    check_sb("R9 disabled");
    // R9 enable dropped mid-count loses the arm
    @(negedge clk) en_r = 1'b1;
    pulse_start(c0);
    wait_n(10);
    @(negedge clk) en_r = 1'b0;
    @(negedge clk) en_r = 1'b1;
    wait_n(2 * T);
    idle_bus();
    check_sb("R9 drop");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule